// File: doc/BRIEF.md
# Ring-Oscillator Bank Health Supervisor

This block watches a bank of free-running ring oscillators that supply raw bits to a true random number generator. Each oscillator has a repeat-detect line, and on every sample strobe the block counts how many samples in a row each enabled oscillator has repeated. When an oscillator's run reaches a programmable limit, the block stops that oscillator. It clears the oscillator's enable bit and records it in a stopped bitmap. The block also keeps a count of stopped oscillators and raises a sticky overflow status once that count goes above a second programmable limit.

Samples from the enabled oscillators are folded into a 64-bit window. After a programmable startup delay, each complete window is published as a 64-bit value behind a ready flag. The value stays frozen until software acknowledges it. An overflow blocks publication. Software recovers a stalled bank as follows: it reads the stopped bitmap, XORs it into the detune mask, writes the stopped bitmap to zero, re-enables the oscillators and acknowledges the overflow. A self-timed soft reset returns every register to its reset value.

Top module: `osc_health_sup`

## Requirements
- R1: Registers are word-aligned at byte offsets 0x00 value low, 0x04 value high, 0x08 status (bit 0 ready, bit 1 overflow), 0x0C acknowledge, 0x10 control (bit 10 enable, bits 31:16 startup cycles), 0x14 limits (bits 7:0 alarm limit, bits 20:16 shutdown limit), 0x18 oscillator enable (bits 23:0), 0x1C detune (bits 23:0), 0x20 stopped bitmap (bits 23:0) and 0x24 soft reset (bit 0). Bits with no field read 0, and every register reads 0 after reset.
- R2: On each sample strobe, an enabled oscillator whose repeat line is high extends its run by one, and a low repeat line restarts the run. An alarm fires on the sample that brings the run to the alarm limit, and a limit of 0 behaves like 1.
- R3: On the clock edge that takes the alarming sample, the oscillator's stopped bit is set and its enable bit is cleared. The oscillator's run count also restarts from zero.
- R4: A write to the stopped bitmap keeps only the bits that are 1 in both the written data and the current bitmap, so writing zero clears it. Alarms raised in the same cycle are still recorded.
- R5: The overflow status is set one clock after the number of stopped bits exceeds the shutdown limit. Writing 1 to acknowledge bit 1 clears it, but only once the stopped count no longer exceeds the limit.
- R6: No bits are collected and ready cannot rise until startup-cycles + 1 clocks have passed since the enable bit was set. Clearing the enable bit stops collection and discards the partial window.
- R7: Each collected sample adds one bit: the parity of (raw bits XOR detune) AND enable mask. The last 64 bits form the value, and the oldest bit lands in bit 31 of the high word.
- R8: Ready rises one clock after the 64th collected bit. While ready is set, the value does not change. Writing 1 to acknowledge bit 0 clears ready, and a new value appears only after a further full window.
- R9: While overflow is set, ready does not rise. Once overflow clears, a completed window is published on the following clock.
- R10: Writing 1 to soft-reset bit 0 makes that bit read 1 for a few clocks, then 0. During this time all other state returns to its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| smp_valid | input | 1 | Sample strobe for the oscillator bank |
| osc_repeat | input | 24 | Per-oscillator repeat-detect flags |
| osc_raw | input | 24 | Per-oscillator raw sample bits |

## Verification
The bench sweeps the alarm limit, including the value 0, on different oscillators. A design that counts off by one, or that fails to restart a run on a non-repeating sample, stops the oscillator one sample early or late. It also sweeps the shutdown limit against the number of simultaneous alarms. Getting the comparison wrong, or clearing overflow while the condition persists, shows up as a wrong status bit. Windows are checked for bit order, for detune and enable masking, for freezing while ready is high, and for exact ready timing. A design that ignores the startup delay or an overflow block publishes a value too early.

// File: rtl/osc_health_pkg.sv
`timescale 1ns/1ps
package osc_health_pkg;
  localparam int BUS_W       = 32;
  localparam int REG_IDX_W   = 4;
  localparam int BUS_ADDR_W  = REG_IDX_W + 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_OUT_LO  = 4'd0,
    REG_OUT_HI  = 4'd1,
    REG_STATUS  = 4'd2,
    REG_ACK     = 4'd3,
    REG_CTRL    = 4'd4,
    REG_LIMITS  = 4'd5,
    REG_OSC_EN  = 4'd6,
    REG_DETUNE  = 4'd7,
    REG_STOPPED = 4'd8,
    REG_SRST    = 4'd9
  } reg_idx_e;

  localparam int ST_READY_BIT   = 0;
  localparam int ST_OVF_BIT     = 1;
  localparam int CTRL_EN_BIT    = 10;
  localparam int CTRL_START_LSB = 16;
  localparam int LIM_ALARM_LSB  = 0;
  localparam int LIM_SHUT_LSB   = 16;
  localparam int SRST_BIT       = 0;
endpackage

// File: rtl/osc_repeat_mon.sv
`timescale 1ns/1ps
module osc_repeat_mon #(
  parameter int NUM_OSC = 24,
  parameter int THR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               smp_valid,
  input  logic [NUM_OSC-1:0] osc_en,
  input  logic [NUM_OSC-1:0] osc_repeat,
  input  logic [THR_W-1:0]   alarm_thr,
  output logic [NUM_OSC-1:0] alarm
);
  localparam int CNT_W = THR_W + 1;

  logic [CNT_W-1:0] thr_ext;
  assign thr_ext = {1'b0, alarm_thr};

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] run_inc;
    logic             run_ce;
    logic             hit;

    always_comb begin
      run_inc = run_q + CNT_W'(1);
      hit     = smp_valid && osc_en[g] && osc_repeat[g] && (run_inc >= thr_ext);
      run_ce  = clr || !osc_en[g] || smp_valid;
      run_d   = run_q;
      if (clr || !osc_en[g]) begin
        run_d = '0;
      end else if (smp_valid) begin
        if (!osc_repeat[g] || hit) run_d = '0;
        else                       run_d = run_inc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (run_ce) run_q <= run_d;
    end

    assign alarm[g] = hit && !clr;
  end
endmodule

// File: rtl/osc_startup_gate.sv
`timescale 1ns/1ps
module osc_startup_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         enable,
  input  logic [W-1:0] cycles,
  output logic         started
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         started_q, started_d;
  logic         ce;

  always_comb begin
    cnt_d     = cnt_q;
    started_d = started_q;
    ce        = 1'b0;
    if (clr || !enable) begin
      cnt_d     = '0;
      started_d = 1'b0;
      ce        = 1'b1;
    end else if (!started_q) begin
      ce = 1'b1;
      if (cnt_q == cycles) started_d = 1'b1;
      else                 cnt_d     = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (ce) begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
    end
  end

  assign started = started_q;
endmodule

// File: rtl/osc_entropy_acc.sv
`timescale 1ns/1ps
module osc_entropy_acc #(
  parameter int NUM_OSC = 24,
  parameter int OUT_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               smp_valid,
  input  logic               collect,
  input  logic               blocked,
  input  logic               ack,
  input  logic [NUM_OSC-1:0] osc_raw,
  input  logic [NUM_OSC-1:0] detune,
  input  logic [NUM_OSC-1:0] osc_en,
  output logic               ready,
  output logic [OUT_W-1:0]   value
);
  localparam int CNT_W = $clog2(OUT_W + 1);

  logic [OUT_W-1:0] win_q, win_d, val_q, val_d;
  logic [CNT_W-1:0] bits_q, bits_d, bits_base;
  logic             rdy_q, rdy_d;
  logic             new_bit, take, load;

  always_comb begin
    new_bit   = ^((osc_raw ^ detune) & osc_en);
    take      = smp_valid && collect;
    load      = !rdy_q && !blocked && (bits_q == CNT_W'(OUT_W));
    bits_base = load ? '0 : bits_q;
    win_d     = win_q;
    bits_d    = bits_base;
    if (clr || !collect) begin
      win_d  = '0;
      bits_d = '0;
    end else if (take) begin
      win_d = {win_q[OUT_W-2:0], new_bit};
      if (bits_base != CNT_W'(OUT_W)) bits_d = bits_base + CNT_W'(1);
    end
    rdy_d = clr ? 1'b0 : ((rdy_q && !ack) || load);
    val_d = clr ? '0 : (load ? win_q : val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      bits_q <= '0;
      rdy_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      win_q  <= win_d;
      bits_q <= bits_d;
      rdy_q  <= rdy_d;
      if (clr || load) val_q <= val_d;
    end
  end

  assign ready = rdy_q;
  assign value = val_q;
endmodule

// File: rtl/osc_health_sup.sv
`timescale 1ns/1ps
module osc_health_sup
  import osc_health_pkg::*;
#(
  parameter int NUM_OSC     = 24,
  parameter int ALARM_W     = 8,
  parameter int SHUT_W      = 5,
  parameter int START_W     = 16,
  parameter int SRST_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  smp_valid,
  input  logic [NUM_OSC-1:0]    osc_repeat,
  input  logic [NUM_OSC-1:0]    osc_raw
);
  localparam int OUT_W    = 2 * BUS_W;
  localparam int PC_W     = $clog2(NUM_OSC + 1);
  localparam int CMP_W    = ((PC_W > SHUT_W) ? PC_W : SHUT_W) + 1;
  localparam int SRST_CW  = $clog2(SRST_CYCLES + 1);

  reg_idx_e reg_sel;
  logic     wr_ok;
  logic     wr_ctrl, wr_lim, wr_en, wr_det, wr_stop, wr_ack, wr_srst;

  logic                 ctrl_en_q, ctrl_en_d;
  logic [START_W-1:0]   start_cyc_q, start_cyc_d;
  logic [ALARM_W-1:0]   alarm_thr_q, alarm_thr_d;
  logic [SHUT_W-1:0]    shut_thr_q, shut_thr_d;
  logic [NUM_OSC-1:0]   osc_en_q, osc_en_d;
  logic [NUM_OSC-1:0]   detune_q, detune_d;
  logic [NUM_OSC-1:0]   stopped_q, stopped_d;
  logic                 ovf_q, ovf_d;
  logic                 srst_busy_q, srst_busy_d;
  logic [SRST_CW-1:0]   srst_cnt_q, srst_cnt_d;

  logic                 clr;
  logic [NUM_OSC-1:0]   alarm;
  logic                 started_w;
  logic                 ready_w;
  logic [OUT_W-1:0]     out_value;
  logic [PC_W-1:0]      stop_cnt;
  logic                 over;

  assign clr = srst_busy_q;

  // Write decode: word-aligned accesses only, ignored during soft reset
  always_comb begin
    reg_sel = reg_idx_e'(bus_addr[BUS_ADDR_W-1:2]);
    wr_ok   = bus_we && (bus_addr[1:0] == 2'b00) && !srst_busy_q;
    wr_ctrl = wr_ok && (reg_sel == REG_CTRL);
    wr_lim  = wr_ok && (reg_sel == REG_LIMITS);
    wr_en   = wr_ok && (reg_sel == REG_OSC_EN);
    wr_det  = wr_ok && (reg_sel == REG_DETUNE);
    wr_stop = wr_ok && (reg_sel == REG_STOPPED);
    wr_ack  = wr_ok && (reg_sel == REG_ACK);
    wr_srst = wr_ok && (reg_sel == REG_SRST) && bus_wdata[SRST_BIT];
  end

  osc_repeat_mon #(
    .NUM_OSC (NUM_OSC),
    .THR_W   (ALARM_W)
  ) u_repeat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .smp_valid  (smp_valid),
    .osc_en     (osc_en_q),
    .osc_repeat (osc_repeat),
    .alarm_thr  (alarm_thr_q),
    .alarm      (alarm)
  );

  osc_startup_gate #(
    .W (START_W)
  ) u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .enable  (ctrl_en_q),
    .cycles  (start_cyc_q),
    .started (started_w)
  );

  osc_entropy_acc #(
    .NUM_OSC (NUM_OSC),
    .OUT_W   (OUT_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .smp_valid (smp_valid),
    .collect   (started_w),
    .blocked   (ovf_q),
    .ack       (wr_ack && bus_wdata[ST_READY_BIT]),
    .osc_raw   (osc_raw),
    .detune    (detune_q),
    .osc_en    (osc_en_q),
    .ready     (ready_w),
    .value     (out_value)
  );

  // Stopped-oscillator population count
  always_comb begin
    stop_cnt = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      stop_cnt = stop_cnt + PC_W'(stopped_q[i]);
    end
    over = CMP_W'(stop_cnt) > CMP_W'(shut_thr_q);
  end

  // Next-state logic for the register file
  always_comb begin
    ctrl_en_d   = ctrl_en_q;
    start_cyc_d = start_cyc_q;
    alarm_thr_d = alarm_thr_q;
    shut_thr_d  = shut_thr_q;
    detune_d    = detune_q;
    if (wr_ctrl) begin
      ctrl_en_d   = bus_wdata[CTRL_EN_BIT];
      start_cyc_d = bus_wdata[CTRL_START_LSB +: START_W];
    end
    if (wr_lim) begin
      alarm_thr_d = bus_wdata[LIM_ALARM_LSB +: ALARM_W];
      shut_thr_d  = bus_wdata[LIM_SHUT_LSB +: SHUT_W];
    end
    if (wr_det) detune_d = bus_wdata[NUM_OSC-1:0];

    osc_en_d  = (wr_en ? bus_wdata[NUM_OSC-1:0] : osc_en_q) & ~alarm;
    stopped_d = (wr_stop ? (stopped_q & bus_wdata[NUM_OSC-1:0]) : stopped_q) | alarm;
    ovf_d     = (ovf_q && !(wr_ack && bus_wdata[ST_OVF_BIT])) || over;

    if (clr) begin
      ctrl_en_d   = 1'b0;
      start_cyc_d = '0;
      alarm_thr_d = '0;
      shut_thr_d  = '0;
      detune_d    = '0;
      osc_en_d    = '0;
      stopped_d   = '0;
      ovf_d       = 1'b0;
    end
  end

  // Soft-reset sequencer
  always_comb begin
    srst_busy_d = srst_busy_q;
    srst_cnt_d  = srst_cnt_q;
    if (wr_srst) begin
      srst_busy_d = 1'b1;
      srst_cnt_d  = '0;
    end else if (srst_busy_q) begin
      if (srst_cnt_q == SRST_CW'(SRST_CYCLES - 1)) srst_busy_d = 1'b0;
      else                                          srst_cnt_d  = srst_cnt_q + SRST_CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q   <= 1'b0;
      start_cyc_q <= '0;
      alarm_thr_q <= '0;
      shut_thr_q  <= '0;
      osc_en_q    <= '0;
      detune_q    <= '0;
      stopped_q   <= '0;
      ovf_q       <= 1'b0;
      srst_busy_q <= 1'b0;
      srst_cnt_q  <= '0;
    end else begin
      ctrl_en_q   <= ctrl_en_d;
      start_cyc_q <= start_cyc_d;
      alarm_thr_q <= alarm_thr_d;
      shut_thr_q  <= shut_thr_d;
      osc_en_q    <= osc_en_d;
      detune_q    <= detune_d;
      stopped_q   <= stopped_d;
      ovf_q       <= ovf_d;
      srst_busy_q <= srst_busy_d;
      srst_cnt_q  <= srst_cnt_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel)
      REG_OUT_LO:  bus_rdata = out_value[BUS_W-1:0];
      REG_OUT_HI:  bus_rdata = out_value[OUT_W-1:BUS_W];
      REG_STATUS: begin
        bus_rdata[ST_READY_BIT] = ready_w;
        bus_rdata[ST_OVF_BIT]   = ovf_q;
      end
      REG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]                   = ctrl_en_q;
        bus_rdata[CTRL_START_LSB +: START_W]     = start_cyc_q;
      end
      REG_LIMITS: begin
        bus_rdata[LIM_ALARM_LSB +: ALARM_W]      = alarm_thr_q;
        bus_rdata[LIM_SHUT_LSB +: SHUT_W]        = shut_thr_q;
      end
      REG_OSC_EN:  bus_rdata = BUS_W'(osc_en_q);
      REG_DETUNE:  bus_rdata = BUS_W'(detune_q);
      REG_STOPPED: bus_rdata = BUS_W'(stopped_q);
      REG_SRST:    bus_rdata[SRST_BIT] = srst_busy_q;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/osc_health_sup_chk.sv
`timescale 1ns/1ps
module osc_health_sup_chk #(
  parameter int NUM_OSC = 24,
  parameter int SHUT_W  = 5,
  parameter int OUT_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               ovf,
  input logic [OUT_W-1:0]   data,
  input logic [NUM_OSC-1:0] stopped,
  input logic [NUM_OSC-1:0] osc_en,
  input logic               started,
  input logic               busy,
  input logic [SHUT_W-1:0]  shut_thr
);
  // R3
  stop_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stopped & ~$past(stopped) & osc_en) == '0));

  // R9
  no_ready_in_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(ovf));

  // R8
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(data));

  // R6
  ready_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(started));

  // R5
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ($countones(stopped) > int'(shut_thr))) |=> ovf);

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!ready && !ovf && (stopped == '0) && (osc_en == '0)));
endmodule

bind osc_health_sup osc_health_sup_chk #(
  .NUM_OSC (NUM_OSC),
  .SHUT_W  (SHUT_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready_w),
  .ovf      (ovf_q),
  .data     (out_value),
  .stopped  (stopped_q),
  .osc_en   (osc_en_q),
  .started  (started_w),
  .busy     (srst_busy_q),
  .shut_thr (shut_thr_q)
);

// File: tb/osc_health_sup_test.sv
`timescale 1ns/1ps
module osc_health_sup_test;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_ST = 6'h08, A_ACK = 6'h0C,
                         A_CTRL = 6'h10, A_LIM = 6'h14, A_EN = 6'h18, A_DET = 6'h1C,
                         A_STOP = 6'h20, A_SRST = 6'h24;

  logic        clk, rst_n, bus_we, smp_valid;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [23:0] osc_repeat, osc_raw;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] m_val = '0;
  logic [23:0] m_en = '0, m_det = '0;
  logic [31:0] rs = 32'h1234_5678;

  osc_health_sup uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .osc_repeat(osc_repeat), .osc_raw(osc_raw)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic nxt();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
  endtask

  task automatic smp(input logic [23:0] rep, input logic [23:0] raw);
    @(negedge clk); smp_valid = 1'b1; osc_repeat = rep; osc_raw = raw;
    m_val = {m_val[62:0], ^((raw ^ m_det) & m_en)};
    @(negedge clk); smp_valid = 1'b0; osc_repeat = '0;
  endtask

  task automatic smp_rand(input int n);
    for (int k = 0; k < n; k++) begin nxt(); smp(24'h0, rs[23:0]); end
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    smp_valid = 1'b0; osc_repeat = '0; osc_raw = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (d2[i]) begin end
    rd(A_ST, d);   chk("R1 status reset", d, 0);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 0);
    rd(A_EN, d);   chk("R1 enable reset", d, 0);
    rd(A_STOP, d); chk("R1 stopped reset", d, 0);
    rd(A_SRST, d); chk("R1 srst reset", d, 0);
    rd(A_LO, d);   chk("R1 value reset", d, 0);

    // R1 field masks
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R1 ctrl fields", d, 32'hFFFF_0400);
    wr(A_CTRL, 32'h0);
    wr(A_LIM, 32'hFFFF_FFFF);  rd(A_LIM, d);  chk("R1 limits fields", d, 32'h001F_00FF);
    wr(A_EN, 32'hFFFF_FFFF);   rd(A_EN, d);   chk("R1 enable field", d, 32'h00FF_FFFF);
    wr(A_DET, 32'hA5A5_A5A5);  rd(A_DET, d);  chk("R1 detune field", d, 32'h00A5_A5A5);
    wr(A_DET, 32'h0);

    // R2 / R3 / R4 alarm-limit sweep
    for (int t = 0; t < 14; t++) begin
      int eff, idx;
      logic [23:0] b;
      eff = (t == 0) ? 1 : t;
      idx = (t * 5) % 24;
      b = 24'h1 << idx;
      wr(A_LIM, {11'h0, 5'h1F, 8'h0, 8'(t)});
      wr(A_EN, 32'h00FF_FFFF);
      if (eff > 1) begin
        for (int k = 0; k < eff - 1; k++) smp(b, 24'h0);
        rd(A_STOP, d); chk("R2 below limit", d, 0);
        smp(24'h0, 24'h0);
        for (int k = 0; k < eff - 1; k++) smp(b, 24'h0);
        rd(A_STOP, d); chk("R2 run restarted", d, 0);
      end
      smp(b, 24'h0);
      rd(A_STOP, d); chk("R2 R3 stopped bit", d, {8'h0, b});
      rd(A_EN, d);   chk("R3 enable cleared", d, {8'h0, 24'hFF_FFFF & ~b});
      wr(A_EN, 32'h00FF_FFFF);
      if (eff > 1) begin
        for (int k = 0; k < eff - 1; k++) smp(b, 24'h0);
        rd(A_EN, d); chk("R3 count restarted", d, 32'h00FF_FFFF);
        smp(24'h0, 24'h0);
      end
      wr(A_STOP, 32'hFFFF_FFFF); rd(A_STOP, d); chk("R4 and-write keeps", d, {8'h0, b});
      wr(A_STOP, 32'h0);         rd(A_STOP, d); chk("R4 zero clears", d, 0);
    end

    // R4 detune recovery flow
    wr(A_LIM, 32'h001F_0001);
    wr(A_DET, 32'h0000_0F0F);
    smp(24'h00_0101, 24'h0);
    rd(A_STOP, d); rd(A_DET, d2);
    wr(A_DET, d ^ d2);
    rd(A_DET, d2); chk("R4 detune xor", d2, 32'h0000_0E0E);
    wr(A_STOP, 32'h0);
    wr(A_DET, 32'h0);

    // R5 shutdown-limit sweep
    for (int th = 0; th < 4; th++) begin
      for (int k = 0; k <= th + 2; k++) begin
        wr(A_LIM, {11'h0, 5'(th), 16'h0001});
        wr(A_STOP, 32'h0);
        wr(A_EN, 32'h00FF_FFFF);
        wr(A_ACK, 32'h2);
        smp(24'((1 << k) - 1), 24'h0);
        rd(A_ST, d); chk("R5 not yet", d, 0);
        @(negedge clk);
        rd(A_ST, d); chk("R5 overflow level", d, (k > th) ? 32'h2 : 32'h0);
        if (k > th) begin
          wr(A_ACK, 32'h2);
          rd(A_ST, d); chk("R5 ack while over", d, 32'h2);
          wr(A_STOP, 32'h0);
          wr(A_ACK, 32'h2);
          rd(A_ST, d); chk("R5 ack clears", d, 0);
        end
      end
    end

    // R6 / R7 / R8 output windows
    wr(A_LIM, 32'h001F_00FF);
    wr(A_STOP, 32'h0);
    wr(A_EN, 32'h00FF_FFFF); m_en = 24'hFF_FFFF;
    wr(A_DET, 32'h003C_0F00); m_det = 24'h3C_0F00;
    wr(A_ACK, 32'h3);
    wr(A_CTRL, (32'd200 << 16) | 32'h400);
    smp_rand(70);
    rd(A_ST, d); chk("R6 no ready during startup", d, 0);
    repeat (80) @(negedge clk);
    smp_rand(64);
    rd(A_ST, d); chk("R8 ready not before next clock", d, 0);
    @(negedge clk);
    rd(A_ST, d); chk("R8 ready after window", d, 32'h1);
    rd(A_HI, d); chk("R7 high word", d, m_val[63:32]);
    rd(A_LO, d); chk("R7 low word", d, m_val[31:0]);
    d2 = m_val[31:0];
    wr(A_EN, 32'h000F_F00F); m_en = 24'h0F_F00F;
    smp_rand(10);
    rd(A_LO, d); chk("R8 value frozen", d, d2);
    wr(A_ACK, 32'h1);
    rd(A_ST, d); chk("R8 ack clears ready", d, 0);
    smp_rand(54);
    @(negedge clk);
    rd(A_ST, d); chk("R8 second ready", d, 32'h1);
    rd(A_HI, d); chk("R7 masked high", d, m_val[63:32]);
    rd(A_LO, d); chk("R7 masked low", d, m_val[31:0]);

    // R9 overflow blocks ready
    wr(A_ACK, 32'h1);
    wr(A_LIM, 32'h0000_0001);
    nxt(); smp(24'h00_0008, rs[23:0]); m_en = m_en & ~24'h8;
    smp_rand(63);
    @(negedge clk);
    rd(A_ST, d); chk("R9 blocked by overflow", d, 32'h2);
    repeat (5) @(negedge clk);
    rd(A_ST, d); chk("R9 still blocked", d, 32'h2);
    wr(A_STOP, 32'h0);
    wr(A_ACK, 32'h2);
    @(negedge clk);
    rd(A_ST, d); chk("R9 published after clear", d, 32'h1);
    rd(A_HI, d); chk("R9 value high", d, m_val[63:32]);
    rd(A_LO, d); chk("R9 value low", d, m_val[31:0]);

    // R6 disable stops collection
    wr(A_ACK, 32'h1);
    wr(A_CTRL, 32'h0);
    smp_rand(64);
    @(negedge clk); @(negedge clk);
    rd(A_ST, d); chk("R6 disabled no ready", d, 0);

    // R10 soft reset
    wr(A_CTRL, 32'h0000_0400);
    wr(A_SRST, 32'h1);
    rd(A_SRST, d); chk("R10 busy reads one", d, 32'h1);
    repeat (10) @(negedge clk);
    rd(A_SRST, d); chk("R10 busy self clears", d, 0);
    rd(A_CTRL, d); chk("R10 ctrl cleared", d, 0);
    rd(A_EN, d);   chk("R10 enable cleared", d, 0);
    rd(A_DET, d);  chk("R10 detune cleared", d, 0);
    rd(A_LIM, d);  chk("R10 limits cleared", d, 0);
    rd(A_LO, d);   chk("R10 value cleared", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule